// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a synchronous static memory front end with one shared address and control bus and separate data-in and data-out paths. A command (address, read/write select, per-lane write enables) is taken on the rising clock edge while the chip select is high. Read data is resolved in the same cycle and passes through a latch that is transparent while the clock is low. It is therefore valid half a cycle after the edge that took the read.

Writes are late. The data for a write is sampled on the rising edge one cycle after its address. Address, lane mask and data then wait in a one-deep buffer. The buffer reaches the array only when the data of the next write replaces it. Reads compare their address with the buffer and merge the buffered lanes over the array word, so a read always returns the newest data, even right after a write. Output enable and sleep act at once, without the clock, and set the data output to its idle value.

The data word has two 9-bit lanes. Bits 8:0 form lane 0 and bits 17:9 form lane 1, and each lane has its own write enable.

Top module: `lwsram_core`

## Requirements
- R1: A command is registered on a rising edge only if `sel` is 1 and `sleep` is 0 at that edge. Inputs seen while `sleep` is 1 change neither the memory contents nor the buffered write.
- R2: After a read is registered, `rdata` shows the read word once the clock has fallen. The value holds through the following high phase and until the next read.
- R3: The write data for a write registered on edge N is sampled from `wdata` on edge N+1.
- R4: The most recent write waits in a one-deep buffer. The buffer is committed to the array only on the edge where the data of the next write replaces it. Idle, read and deselected cycles leave it pending.
- R5: A read whose address matches the pending write returns the buffered bytes in the lanes that write enabled, and array data in the other lanes.
- R6: A write followed in the next cycle by a read of the same address returns the new data.
- R7: `lane_we[0]` controls `rdata/wdata` bits 8:0 and `lane_we[1]` controls bits 17:9. A disabled lane keeps its earlier contents. `lane_we` has no effect on reads.
- R8: While `oe` is 0, `rdata` is 0 and `rdata_drv` is 0. The change happens as soon as `oe` changes, with no clock edge needed.
- R9: While `sleep` is 1, `rdata` is 0 and `rdata_drv` is 0, again without waiting for a clock edge. The stored contents are kept.
- R10: A synchronous active-low reset empties the write buffer, so a write still pending at reset is dropped and never committed. Reset also clears the output latch to 0.
- R11: A cycle with `sel` = 0 registers no command and leaves both the buffer and the output latch unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commands on rising edge, read latch open while low |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Chip select, 1 = command this cycle |
| wr_en | input | 1 | 1 = write, 0 = read |
| lane_we | input | LANES (2) | Per-lane write enables for a write |
| addr | input | AW (6) | Word address |
| wdata | input | DW (18) | Write data, one cycle after its address |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous power-down |
| rdata | output | DW (18) | Read data, 0 when idle |
| rdata_drv | output | 1 | 1 when `rdata` is being driven |

## Verification
A wrong address, lane mask or valid flag in the write buffer shows up on the first read of that word. That read returns a stale or mixed word in the very cycle it is issued. A buffer that commits too early or too late shows up only when the next write lands and a later read of the first address no longer matches. The bench therefore reads each word again after a second write has displaced it. A latch that opens at the wrong time corrupts `rdata` within half a cycle, and a wrongly gated enable path corrupts `oe` and `sleep` behaviour immediately. Both are sampled inside the clock phase where the fault would appear.

// File: rtl/lwsram_pkg.sv
// Shared types for the late-write SRAM core.
// Assumes: one command per cycle, decoded into a single registered operation.
package lwsram_pkg;

    // Operation held in the command register for the current cycle.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

endpackage

// File: rtl/lwsram_cmd_stage.sv
// Command register: samples address, operation and lane mask on the rising edge.
// Assumes: sel and sleep are stable around the edge; a deselected or sleeping
// cycle registers OP_IDLE and leaves the held address and mask unchanged.
module lwsram_cmd_stage #(
    parameter int AW    = 6,
    parameter int LANES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 wr_en,
    input  logic                 sleep,
    input  logic [LANES-1:0]     lane_we,
    input  logic [AW-1:0]        addr,
    output lwsram_pkg::op_e      op,
    output logic [AW-1:0]        op_addr,
    output logic [LANES-1:0]     op_lanes
);
    import lwsram_pkg::*;

    // Capture one command per edge, or idle when deselected or asleep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op       <= OP_IDLE;
            op_addr  <= '0;
            op_lanes <= '0;
        end else if (sel && !sleep) begin
            op       <= wr_en ? OP_WRITE : OP_READ;
            op_addr  <= addr;
            op_lanes <= lane_we;
        end else begin
            op       <= OP_IDLE;
        end
    end

endmodule

// File: rtl/lwsram_wbuf.sv
// One-deep late-write buffer: on the edge after a registered write it takes the
// write data together with the registered address and lane mask.
// The previous content is handed to the array on that same edge.
// Assumes: the array writes on the same rising edge the commit strobe is high.
module lwsram_wbuf #(
    parameter int AW    = 6,
    parameter int LANES = 2,
    parameter int LW    = 9,
    localparam int DW   = LANES * LW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  lwsram_pkg::op_e      op,
    input  logic [AW-1:0]        op_addr,
    input  logic [LANES-1:0]     op_lanes,
    input  logic [DW-1:0]        wdata,
    output logic                 buf_valid,
    output logic [AW-1:0]        buf_addr,
    output logic [LANES-1:0]     buf_lanes,
    output logic [DW-1:0]        buf_data,
    output logic                 commit
);
    import lwsram_pkg::*;

    // The held write goes to the array only when a newer write displaces it.
    assign commit = (op == OP_WRITE) && buf_valid;

    // Replace the buffer with the write whose data arrives this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_valid <= 1'b0;
            buf_addr  <= '0;
            buf_lanes <= '0;
            buf_data  <= '0;
        end else if (op == OP_WRITE) begin
            buf_valid <= 1'b1;
            buf_addr  <= op_addr;
            buf_lanes <= op_lanes;
            buf_data  <= wdata;
        end
    end

endmodule

// File: rtl/lwsram_array.sv
// Storage array: one memory per lane, lane-masked synchronous write port,
// combinational read port.
// Assumes: contents are not reset; only words written before are read.
module lwsram_array #(
    parameter int AW    = 6,
    parameter int LANES = 2,
    parameter int LW    = 9,
    localparam int DW    = LANES * LW,
    localparam int DEPTH = 1 << AW
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic [LANES-1:0]     wlanes,
    input  logic [DW-1:0]        wdata,
    input  logic [AW-1:0]        raddr,
    output logic [DW-1:0]        rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] mem [DEPTH];

        // Write this lane when the commit strobe selects it.
        always_ff @(posedge clk) begin
            if (we && wlanes[g]) begin
                mem[waddr] <= wdata[g*LW +: LW];
            end
        end

        assign rdata[g*LW +: LW] = mem[raddr];
    end

endmodule

// File: rtl/lwsram_rd_path.sv
// Read path: merges the pending write over the array word lane by lane, holds
// the result in a latch that is open while the clock is low during a read,
// and gates the output with the asynchronous enable and sleep inputs.
// Assumes: op and op_addr only change on rising edges, so they are steady
// while the latch is open.
module lwsram_rd_path #(
    parameter int AW    = 6,
    parameter int LANES = 2,
    parameter int LW    = 9,
    localparam int DW   = LANES * LW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  lwsram_pkg::op_e      op,
    input  logic [AW-1:0]        op_addr,
    input  logic [DW-1:0]        arr_data,
    input  logic                 buf_valid,
    input  logic [AW-1:0]        buf_addr,
    input  logic [LANES-1:0]     buf_lanes,
    input  logic [DW-1:0]        buf_data,
    input  logic                 oe,
    input  logic                 sleep,
    output logic [DW-1:0]        hold_q,
    output logic [DW-1:0]        rdata,
    output logic                 rdata_drv
);
    import lwsram_pkg::*;

    logic          hit;
    logic [DW-1:0] merged;

    // Address match against the pending write.
    assign hit = buf_valid && (buf_addr == op_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_merge
        assign merged[g*LW +: LW] = (hit && buf_lanes[g]) ? buf_data[g*LW +: LW]
                                                          : arr_data[g*LW +: LW];
    end

    // Output latch: transparent in the low phase of a read cycle.
    always_latch begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (!clk && (op == OP_READ)) begin
            hold_q <= merged;
        end
    end

    assign rdata_drv = oe && !sleep;
    assign rdata     = rdata_drv ? hold_q : '0;

endmodule

// File: rtl/lwsram_core.sv
// Late-write synchronous SRAM core: command register, one-deep write buffer,
// lane-masked array and coherent latched read path.
// Assumes: one command per cycle; write data is presented one cycle after
// its address; oe and sleep may change at any time.
module lwsram_core #(
    parameter int AW    = 6,
    parameter int LANES = 2,
    parameter int LW    = 9,
    localparam int DW   = LANES * LW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 wr_en,
    input  logic [LANES-1:0]     lane_we,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    input  logic                 oe,
    input  logic                 sleep,
    output logic [DW-1:0]        rdata,
    output logic                 rdata_drv
);
    import lwsram_pkg::*;

    op_e              op;
    logic [AW-1:0]    op_addr;
    logic [LANES-1:0] op_lanes;
    logic             buf_valid;
    logic [AW-1:0]    buf_addr;
    logic [LANES-1:0] buf_lanes;
    logic [DW-1:0]    buf_data;
    logic             commit;
    logic [DW-1:0]    arr_data;
    logic [DW-1:0]    hold_q;

    lwsram_cmd_stage #(.AW(AW), .LANES(LANES)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .wr_en    (wr_en),
        .sleep    (sleep),
        .lane_we  (lane_we),
        .addr     (addr),
        .op       (op),
        .op_addr  (op_addr),
        .op_lanes (op_lanes)
    );

    lwsram_wbuf #(.AW(AW), .LANES(LANES), .LW(LW)) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .op_addr   (op_addr),
        .op_lanes  (op_lanes),
        .wdata     (wdata),
        .buf_valid (buf_valid),
        .buf_addr  (buf_addr),
        .buf_lanes (buf_lanes),
        .buf_data  (buf_data),
        .commit    (commit)
    );

    lwsram_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_array (
        .clk    (clk),
        .we     (commit),
        .waddr  (buf_addr),
        .wlanes (buf_lanes),
        .wdata  (buf_data),
        .raddr  (op_addr),
        .rdata  (arr_data)
    );

    lwsram_rd_path #(.AW(AW), .LANES(LANES), .LW(LW)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .op_addr   (op_addr),
        .arr_data  (arr_data),
        .buf_valid (buf_valid),
        .buf_addr  (buf_addr),
        .buf_lanes (buf_lanes),
        .buf_data  (buf_data),
        .oe        (oe),
        .sleep     (sleep),
        .hold_q    (hold_q),
        .rdata     (rdata),
        .rdata_drv (rdata_drv)
    );

endmodule

// File: rtl/lwsram_core_chk.sv
// Protocol checker for lwsram_core, attached by bind.
// Assumes: reset is held low from time zero until the first clock edges.
module lwsram_core_chk #(
    parameter int AW    = 6,
    parameter int LANES = 2,
    parameter int DW    = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 oe,
    input  logic                 sleep,
    input  logic [DW-1:0]        rdata,
    input  logic                 rdata_drv,
    input  lwsram_pkg::op_e      op,
    input  logic [AW-1:0]        op_addr,
    input  logic                 buf_valid,
    input  logic [AW-1:0]        buf_addr,
    input  logic [LANES-1:0]     buf_lanes,
    input  logic [DW-1:0]        buf_data,
    input  logic [DW-1:0]        hold_q
);
    import lwsram_pkg::*;

    a_r1_no_cmd_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep || !sel) |=> (op == OP_IDLE));

    a_r2_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_READ) |-> $stable(hold_q));

    a_r3_write_fills_buf: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE) |=> (buf_valid && buf_addr == $past(op_addr)));

    a_r4_buf_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_WRITE) |=> ($stable(buf_valid) && $stable(buf_addr)
                              && $stable(buf_lanes) && $stable(buf_data)));

    a_r8_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (rdata == '0 && !rdata_drv));

    a_r9_sleep_idle: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (rdata == '0 && !rdata_drv));

    a_r10_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !buf_valid);

endmodule

bind lwsram_core lwsram_core_chk #(.AW(AW), .LANES(LANES), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .oe        (oe),
    .sleep     (sleep),
    .rdata     (rdata),
    .rdata_drv (rdata_drv),
    .op        (op),
    .op_addr   (op_addr),
    .buf_valid (buf_valid),
    .buf_addr  (buf_addr),
    .buf_lanes (buf_lanes),
    .buf_data  (buf_data),
    .hold_q    (hold_q)
);

// File: tb/lwsram_core_test.sv
// Bench for lwsram_core: a vector table walked by one loop, then directed
// tests for latch hold, output enable, sleep and reset.
module lwsram_core_test;
    localparam int PER = 10;
    localparam int NV  = 12;
    // Vector: sel, wr, lane_we[2], addr[6], wdata[18], chk, exp[18] = 47 bits
    localparam logic [46:0] VEC [NV] = '{
        {1'b1, 1'b1, 2'b11, 6'd9, 18'h00000, 1'b0, 18'h00000}, // W A9
        {1'b1, 1'b1, 2'b11, 6'd5, 18'h0ABCD, 1'b0, 18'h00000}, // W A5, data A9
        {1'b1, 1'b0, 2'b00, 6'd5, 18'h2A5A5, 1'b1, 18'h2A5A5}, // R A5 at once
        {1'b1, 1'b1, 2'b01, 6'd5, 18'h00000, 1'b0, 18'h00000}, // W A5 lane 0
        {1'b0, 1'b1, 2'b11, 6'd9, 18'h00123, 1'b0, 18'h00000}, // deselected, data A5
        {1'b1, 1'b0, 2'b00, 6'd5, 18'h00000, 1'b1, 18'h2A523}, // R A5 merged
        {1'b1, 1'b1, 2'b10, 6'd9, 18'h00000, 1'b0, 18'h00000}, // W A9 lane 1
        {1'b1, 1'b1, 2'b11, 6'd5, 18'h3FFFF, 1'b0, 18'h00000}, // W A5, data A9
        {1'b1, 1'b0, 2'b00, 6'd9, 18'h11111, 1'b1, 18'h3FFCD}, // R A9, data A5
        {1'b1, 1'b0, 2'b00, 6'd5, 18'h00000, 1'b1, 18'h11111}, // R A5 pending
        {1'b0, 1'b0, 2'b00, 6'd9, 18'h00000, 1'b1, 18'h11111}, // deselected read
        {1'b1, 1'b0, 2'b11, 6'd9, 18'h00000, 1'b1, 18'h3FFCD}  // R A9, lanes set
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  lane_we = '0;
    logic [5:0]  addr = '0;
    logic [17:0] wdata = '0;
    logic        oe = 1'b1;
    logic        sleep = 1'b0;
    logic [17:0] rdata;
    logic        rdata_drv;
    int          n_run = 0;
    int          n_fail = 0;
    string       tags [NV];

    lwsram_core uut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .lane_we(lane_we),
        .addr(addr), .wdata(wdata), .oe(oe), .sleep(sleep),
        .rdata(rdata), .rdata_drv(rdata_drv)
    );

    always #(PER/2) clk = ~clk;

    task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs, then wait until the low phase after the edge.
    task automatic step(input logic s, input logic w, input logic [1:0] b,
                        input logic [5:0] a, input logic [17:0] d);
        sel = s; wr_en = w; lane_we = b; addr = a; wdata = d;
        @(posedge clk);
        #7;
    endtask

    initial begin
        tags = '{"", "", "R6", "", "", "R5", "", "", "R4", "R3", "R11", "R7"};
        repeat (3) @(posedge clk);
        #7;
        rst_n = 1'b1;
        @(posedge clk);
        #7;
        check("R10 reset rdata", rdata, 18'h0);
        check("R10 reset drv", {17'h0, rdata_drv}, 18'h1);

        for (int i = 0; i < NV; i++) begin
            logic [46:0] v;
            v = VEC[i];
            step(v[46], v[45], v[44:43], v[42:37], v[36:19]);
            if (v[18]) check(tags[i], rdata, v[17:0]);
        end

        // R2: value held through the next high phase and an idle cycle
        sel = 1'b0;
        @(posedge clk);
        #1;
        check("R2 high phase hold", rdata, 18'h3FFCD);

        // R8: asynchronous output enable
        #1;
        oe = 1'b0;
        #1;
        check("R8 oe low rdata", rdata, 18'h0);
        check("R8 oe low drv", {17'h0, rdata_drv}, 18'h0);
        oe = 1'b1;
        #1;
        check("R8 oe restored", rdata, 18'h3FFCD);
        @(posedge clk);
        #7;

        // R9 / R1: sleep idles the output and blocks commands
        sleep = 1'b1;
        #1;
        check("R9 sleep rdata", rdata, 18'h0);
        check("R9 sleep drv", {17'h0, rdata_drv}, 18'h0);
        step(1'b1, 1'b1, 2'b11, 6'd9, 18'h00000);
        step(1'b1, 1'b0, 2'b00, 6'd9, 18'h00000);
        sleep = 1'b0;
        step(1'b1, 1'b0, 2'b00, 6'd9, 18'h00000);
        check("R1 write in sleep ignored", rdata, 18'h3FFCD);

        // R10: a pending write is dropped by reset
        step(1'b1, 1'b1, 2'b11, 6'd3, 18'h00000);
        step(1'b1, 1'b1, 2'b11, 6'd4, 18'h15555);
        step(1'b0, 1'b0, 2'b00, 6'd0, 18'h0AAAA);
        step(1'b1, 1'b1, 2'b11, 6'd3, 18'h00000);
        step(1'b1, 1'b0, 2'b00, 6'd3, 18'h3C3C3);
        check("R5 pending full word", rdata, 18'h3C3C3);
        sel = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #7;
        rst_n = 1'b1;
        check("R10 latch cleared", rdata, 18'h0);
        step(1'b1, 1'b0, 2'b00, 6'd3, 18'h00000);
        check("R10 pending write dropped", rdata, 18'h15555);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(PER * 100000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule